// File: doc/BRIEF.md
# Table-Driven Programmable Interleaver

This block reorders a block of symbols under the control of a permutation table that software or a sequencer fills through a write port. Each table entry names the source symbol for one output position, or tells the engine to do something else at that position: place a constant, leave the position alone, or fold the source symbol into a running group whose signed average is emitted later. Symbols are held in an on-chip input buffer, also filled through a write port, and are 1 to 8 bits wide under a run-time width selector.

A run starts with a one-cycle start pulse carrying the run length and width selector. The engine then walks the table from entry 0, one entry per clock, and emits each produced symbol on an output write stream tagged with its position (the table entry index). A done pulse accompanies the last entry's result. Skipped positions produce no write, so a long permutation can be assembled in several passes over a larger output memory owned by the surrounding system.

Top module: `tbl_perm_interleaver`

## Requirements
- R1: While and directly after reset, `run_busy`, `run_done` and `out_valid` are low.
- R2: A table entry holds a 2-bit mode and a 16-bit index field; modes are 0 = copy, 1 = force, 2 = skip, 3 = accumulate. The entry at address a is used for output position a.
- R3: A copy entry writes the input-buffer symbol at address (index modulo buffer depth) to its position, truncated to the configured width.
- R4: A force entry writes bits [7:0] of its index field, truncated to the configured width, instead of reading the buffer.
- R5: A skip entry produces no output write at its position and leaves any open accumulate group untouched.
- R6: An accumulate entry produces no output write; it adds its source symbol (read as for copy) to a running sum and increments a count.
- R7: A copy or force entry that follows one or more accumulate entries closes the group: its own value joins the sum, and its position receives sum divided by (count + 1), rounded toward zero, after which the group is empty.
- R8: `run_wsel` selects a width of `run_wsel`+1 bits. Values are sign-extended from that width for averaging, and every output symbol has all bits above that width at zero.
- R9: A start pulse seen at clock edge E0 while idle makes the result of entry p appear after edge E0+p+1; `run_done` is high for exactly one cycle, after edge E0+len, together with the last entry's result.
- R10: A run length of zero produces no output and raises `run_done` for one cycle after the start edge, with `run_busy` staying low.
- R11: A start pulse while `run_busy` is high is ignored: the current run's outputs, length and width are unchanged and no extra done pulse occurs.
- R12: Each run begins with an empty accumulate group; a group left open at the end of a run is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | TBL_AW (6) | Table write address |
| tbl_wmode | input | 2 | Mode of the entry written |
| tbl_windex | input | 16 | Index field of the entry written |
| sym_we | input | 1 | Input buffer write enable |
| sym_waddr | input | SYM_AW (6) | Input buffer write address |
| sym_wdata | input | 8 | Symbol written |
| run_start | input | 1 | Start pulse |
| run_len | input | 17 | Number of table entries in the run |
| run_wsel | input | 3 | Symbol width minus one |
| run_busy | output | 1 | Run in progress |
| run_done | output | 1 | One-cycle end-of-run pulse |
| out_valid | output | 1 | Output write strobe |
| out_pos | output | 17 | Output position (table entry index) |
| out_data | output | 8 | Output symbol, zero above the configured width |

## Verification
A corrupted accumulator shows up as a wrong value on the very next closing copy or force entry, one cycle after that entry is reached, while a stuck or mis-stepped entry pointer shifts every following position and timestamp and is seen on the first output after the fault. A wrong mode decode either emits a write at a skipped or accumulating position or omits an expected one, which the scoreboard sees as a position or cycle mismatch at once. A lost done pulse or a restart during a run shows as a missing or extra pulse within a few cycles of the run's expected end.

// File: rtl/il_pkg.sv
package il_pkg;

    localparam int SYM_W  = 8;
    localparam int IDX_W  = 16;
    localparam int LEN_W  = 17;
    localparam int WSEL_W = $clog2(SYM_W);

    typedef enum logic [1:0] {
        MODE_COPY  = 2'd0,
        MODE_FORCE = 2'd1,
        MODE_SKIP  = 2'd2,
        MODE_ACC   = 2'd3
    } il_mode_e;

    typedef struct packed {
        il_mode_e               mode;
        logic [IDX_W-1:0]       idx;
    } il_entry_t;

    function automatic logic [SYM_W-1:0] sym_mask(input logic [WSEL_W-1:0] wsel);
        logic [SYM_W-1:0] m;
        for (int i = 0; i < SYM_W; i++)
            m[i] = (i <= int'(wsel));
        return m;
    endfunction

    function automatic logic [SYM_W-1:0] sym_sext(input logic [SYM_W-1:0] v,
                                                  input logic [WSEL_W-1:0] wsel);
        logic [SYM_W-1:0] r;
        r = v;
        for (int i = 0; i < SYM_W; i++)
            if (i > int'(wsel))
                r[i] = v[wsel];
        return r;
    endfunction

endpackage

// File: rtl/il_table.sv
module il_table
    import il_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  il_entry_t       wentry,
    input  logic [AW-1:0]   raddr,
    output il_entry_t       rentry
);
    il_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wentry;
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/il_symbuf.sv
module il_symbuf
    import il_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [SYM_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [SYM_W-1:0] rdata
);
    logic [SYM_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/il_avg.sv
module il_avg
    import il_pkg::*;
#(
    parameter int CNT_W = LEN_W,
    localparam int SUM_W = SYM_W + CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    acc_en,
    input  logic                    close_en,
    input  logic signed [SYM_W-1:0] val,
    output logic [SYM_W-1:0]        avg
);
    logic signed [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [SUM_W-1:0] val_x;
    logic signed [SUM_W-1:0] num;
    logic signed [SUM_W-1:0] den;
    logic signed [SUM_W-1:0] quo;

    always_comb begin
        val_x = SUM_W'(val);
        num   = sum_q + val_x;
        den   = $signed(SUM_W'(cnt_q)) + SUM_W'(1);
        quo   = num / den;
        avg   = quo[SYM_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr || close_en) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (acc_en) begin
            sum_q <= num;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7: a closing entry with an empty group passes its own value through
    p_single_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (close_en && cnt_q == '0) |-> (avg == val));

    // R12: a start clears any open group before the first entry
    p_group_clear_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/il_engine.sv
module il_engine
    import il_pkg::*;
#(
    parameter int TBL_AW = 6,
    parameter int SYM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_start,
    input  logic [LEN_W-1:0]  run_len,
    input  logic [WSEL_W-1:0] run_wsel,
    output logic              run_busy,
    output logic              run_done,
    output logic [TBL_AW-1:0] tbl_raddr,
    input  il_entry_t         tbl_entry,
    output logic [SYM_AW-1:0] sym_raddr,
    input  logic [SYM_W-1:0]  sym_rdata,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_pos,
    output logic [SYM_W-1:0]  out_data
);
    logic [LEN_W-1:0]  ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [WSEL_W-1:0] wsel_q;
    logic              busy_q;

    logic              is_close;
    logic              is_acc;
    logic              launch;
    logic [SYM_W-1:0]  raw_sym;
    logic [SYM_W-1:0]  ext_sym;
    logic [SYM_W-1:0]  avg_sym;
    logic              unused_idx_hi;

    assign tbl_raddr = ptr_q[TBL_AW-1:0];
    assign sym_raddr = tbl_entry.idx[SYM_AW-1:0];
    assign unused_idx_hi = ^tbl_entry.idx;

    assign launch   = !busy_q && run_start;
    assign is_close = busy_q && (tbl_entry.mode == MODE_COPY || tbl_entry.mode == MODE_FORCE);
    assign is_acc   = busy_q && (tbl_entry.mode == MODE_ACC);

    always_comb begin
        raw_sym = (tbl_entry.mode == MODE_FORCE) ? tbl_entry.idx[SYM_W-1:0] : sym_rdata;
        ext_sym = sym_sext(raw_sym, wsel_q);
    end

    il_avg #(.CNT_W(LEN_W)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .clr      (launch),
        .acc_en   (is_acc),
        .close_en (is_close),
        .val      ($signed(ext_sym)),
        .avg      (avg_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            ptr_q     <= '0;
            len_q     <= '0;
            wsel_q    <= '0;
            run_done  <= 1'b0;
            out_valid <= 1'b0;
            out_pos   <= '0;
            out_data  <= '0;
        end else begin
            run_done  <= 1'b0;
            out_valid <= 1'b0;
            if (launch) begin
                len_q  <= run_len;
                wsel_q <= run_wsel;
                ptr_q  <= '0;
                if (run_len == '0)
                    run_done <= 1'b1;
                else
                    busy_q <= 1'b1;
            end else if (busy_q) begin
                if (is_close) begin
                    out_valid <= 1'b1;
                    out_pos   <= ptr_q;
                    out_data  <= avg_sym & sym_mask(wsel_q);
                end
                ptr_q <= ptr_q + LEN_W'(1);
                if (ptr_q == len_q - LEN_W'(1)) begin
                    busy_q   <= 1'b0;
                    run_done <= 1'b1;
                end
            end
        end
    end

    assign run_busy = busy_q;

    // R1: nothing is produced in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !run_done && !run_busy));

    // R5: a skip entry produces no write
    p_skip_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && tbl_entry.mode == MODE_SKIP) |=> !out_valid);

    // R6: an accumulate entry produces no write
    p_acc_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && tbl_entry.mode == MODE_ACC) |=> !out_valid);

    // R8: bits above the configured width stay zero
    p_trunc_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~sym_mask(wsel_q)) == '0));

    // R9: done is a single-cycle pulse and ends the busy phase
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        run_done |-> (!run_busy ##1 !run_done));

    // R10: a zero-length start completes at once without becoming busy
    p_len_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (!run_busy && run_start && run_len == '0) |=> (run_done && !run_busy));

    // R11: a start during a run leaves the run's settings alone
    p_ignore_start_r11: assert property (@(posedge clk) disable iff (rst)
        (run_busy && run_start) |=> ($stable(len_q) && $stable(wsel_q)));
endmodule

// File: rtl/tbl_perm_interleaver.sv
module tbl_perm_interleaver
    import il_pkg::*;
#(
    parameter int TBL_DEPTH = 64,
    parameter int SYM_DEPTH = 64,
    localparam int TBL_AW   = $clog2(TBL_DEPTH),
    localparam int SYM_AW   = $clog2(SYM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_waddr,
    input  logic [1:0]        tbl_wmode,
    input  logic [IDX_W-1:0]  tbl_windex,
    input  logic              sym_we,
    input  logic [SYM_AW-1:0] sym_waddr,
    input  logic [SYM_W-1:0]  sym_wdata,
    input  logic              run_start,
    input  logic [LEN_W-1:0]  run_len,
    input  logic [WSEL_W-1:0] run_wsel,
    output logic              run_busy,
    output logic              run_done,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_pos,
    output logic [SYM_W-1:0]  out_data
);
    il_entry_t         wentry;
    il_entry_t         rentry;
    logic [TBL_AW-1:0] tbl_raddr;
    logic [SYM_AW-1:0] sym_raddr;
    logic [SYM_W-1:0]  sym_rdata;

    always_comb begin
        wentry.mode = il_mode_e'(tbl_wmode);
        wentry.idx  = tbl_windex;
    end

    il_table #(.DEPTH(TBL_DEPTH)) u_table (
        .clk    (clk),
        .we     (tbl_we),
        .waddr  (tbl_waddr),
        .wentry (wentry),
        .raddr  (tbl_raddr),
        .rentry (rentry)
    );

    il_symbuf #(.DEPTH(SYM_DEPTH)) u_symbuf (
        .clk   (clk),
        .we    (sym_we),
        .waddr (sym_waddr),
        .wdata (sym_wdata),
        .raddr (sym_raddr),
        .rdata (sym_rdata)
    );

    il_engine #(.TBL_AW(TBL_AW), .SYM_AW(SYM_AW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .run_start (run_start),
        .run_len   (run_len),
        .run_wsel  (run_wsel),
        .run_busy  (run_busy),
        .run_done  (run_done),
        .tbl_raddr (tbl_raddr),
        .tbl_entry (rentry),
        .sym_raddr (sym_raddr),
        .sym_rdata (sym_rdata),
        .out_valid (out_valid),
        .out_pos   (out_pos),
        .out_data  (out_data)
    );
endmodule

// File: tb/tb_tbl_perm_interleaver.sv
module tb_tbl_perm_interleaver;
    localparam int TD = 64;
    localparam int SD = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_waddr = '0;
    logic [1:0]  tbl_wmode = '0;
    logic [15:0] tbl_windex = '0;
    logic        sym_we = 1'b0;
    logic [5:0]  sym_waddr = '0;
    logic [7:0]  sym_wdata = '0;
    logic        run_start = 1'b0;
    logic [16:0] run_len = '0;
    logic [2:0]  run_wsel = '0;
    logic        run_busy, run_done, out_valid;
    logic [16:0] out_pos;
    logic [7:0]  out_data;

    tbl_perm_interleaver dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tmode [TD];
    int tidx  [TD];
    int tsym  [SD];
    int q_pos[$], q_dat[$], q_cyc[$];
    string q_req[$];

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_pos.size() == 0) begin
                check(0, "R5/R6 unexpected write at pos", int'(out_pos), -1);
            end else begin
                int p, d, c;
                string r;
                p = q_pos.pop_front(); d = q_dat.pop_front();
                c = q_cyc.pop_front(); r = q_req.pop_front();
                check(int'(out_pos) == p, {r, " position"}, int'(out_pos), p);
                check(int'(out_data) == d, {r, " data"}, int'(out_data), d);
                check(cyc == c, {r, " cycle (R9)"}, cyc, c);
            end
        end
    end

    function automatic int sx(input int v, input int w);
        int m;
        m = (1 << w) - 1;
        v = v & m;
        if (((v >> (w - 1)) & 1) == 1) v = v - (1 << w);
        return v;
    endfunction

    task automatic wr_tbl(input int a, input int mode, input int idx);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = 6'(a); tbl_wmode = 2'(mode); tbl_windex = 16'(idx);
        tmode[a] = mode; tidx[a] = idx;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_sym(input int a, input int d);
        @(negedge clk);
        sym_we = 1'b1; sym_waddr = 6'(a); sym_wdata = 8'(d);
        tsym[a] = d & 255;
        @(negedge clk);
        sym_we = 1'b0;
    endtask

    // model from the requirements: pushes expected writes
    task automatic model(input int len, input int wsel, input int c0, input string req);
        int w, m, sum, cnt, v, r;
        w = wsel + 1; m = (1 << w) - 1; sum = 0; cnt = 0;
        for (int p = 0; p < len; p++) begin
            case (tmode[p])
                0, 1: begin
                    v = (tmode[p] == 1) ? sx(tidx[p] & 255, w) : sx(tsym[tidx[p] % SD], w);
                    r = (sum + v) / (cnt + 1);
                    q_pos.push_back(p); q_dat.push_back(r & m);
                    q_cyc.push_back(c0 + p + 1); q_req.push_back(req);
                    sum = 0; cnt = 0;
                end
                3: begin
                    sum += sx(tsym[tidx[p] % SD], w);
                    cnt++;
                end
                default: ;
            endcase
        end
    endtask

    task automatic run(input int len, input int wsel, input string req, input bit disturb);
        int c0, ndone, dcyc;
        @(negedge clk);
        c0 = cyc + 1;
        model(len, wsel, c0, req);
        run_start = 1'b1; run_len = 17'(len); run_wsel = 3'(wsel);
        ndone = 0; dcyc = -1;
        for (int k = 0; k < len + 4; k++) begin
            @(negedge clk);
            run_start = 1'b0;
            if (disturb && k == 4) begin
                run_start = 1'b1; run_len = 17'd3; run_wsel = 3'd0;
            end
            if (run_done) begin ndone++; dcyc = cyc; end
        end
        run_start = 1'b0;
        check(ndone == 1, {req, " done pulse count (R9/R11)"}, ndone, 1);
        check(dcyc == c0 + len, {req, " done cycle (R9)"}, dcyc, c0 + len);
        check(q_pos.size() == 0, {req, " missing writes"}, q_pos.size(), 0);
        check(!run_busy, {req, " idle after run"}, int'(run_busy), 0);
        q_pos.delete(); q_dat.delete(); q_cyc.delete(); q_req.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!run_busy && !run_done && !out_valid, "R1 reset state",
              int'({run_busy, run_done, out_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!run_busy && !run_done && !out_valid, "R1 after reset",
              int'({run_busy, run_done, out_valid}), 0);

        for (int i = 0; i < SD; i++) wr_sym(i, (i * 37 + 11) & 255);

        // R2 R3: reversed copy at full width
        for (int p = 0; p < 16; p++) wr_tbl(p, 0, 15 - p);
        run(16, 7, "R2/R3 copy", 0);

        // R4 R5 R8: force / skip / copy at width 5, index above buffer depth
        for (int p = 0; p < 12; p++) begin
            if (p % 3 == 0)      wr_tbl(p, 1, 16'hA500 + 16'hA5 + p);
            else if (p % 3 == 1) wr_tbl(p, 2, p);
            else                 wr_tbl(p, 0, p * 5 + 64);
        end
        run(12, 4, "R4/R5/R8 force-skip", 0);

        // R6 R7: averaging groups with signed values
        wr_sym(40, 253); wr_sym(41, 2); wr_sym(42, 251); wr_sym(43, 254);
        wr_sym(44, 100); wr_sym(45, 101); wr_sym(46, 127);
        wr_tbl(0, 3, 40); wr_tbl(1, 0, 41);
        wr_tbl(2, 3, 42); wr_tbl(3, 2, 0); wr_tbl(4, 0, 43);
        wr_tbl(5, 3, 44); wr_tbl(6, 3, 45); wr_tbl(7, 1, 127);
        wr_tbl(8, 3, 46); wr_tbl(9, 3, 46); wr_tbl(10, 0, 46);
        wr_tbl(11, 0, 44);
        run(12, 7, "R6/R7 average w8", 0);
        // R8: same groups at width 3 and width 1 (sign extension)
        run(12, 2, "R8 average w3", 0);
        run(12, 0, "R8 average w1", 0);

        // R10: zero length
        run(0, 7, "R10 zero length", 0);

        // R11: start while busy is ignored
        for (int p = 0; p < 20; p++) wr_tbl(p, 0, (p * 7) & 63);
        run(20, 7, "R11 start while busy", 1);

        // R12: open group discarded at run end
        wr_tbl(0, 3, 46); wr_tbl(1, 3, 46);
        run(2, 7, "R12 open group", 0);
        wr_tbl(0, 0, 5);
        run(1, 7, "R12 fresh group", 0);

        // full table, mixed modes
        for (int p = 0; p < TD; p++) wr_tbl(p, (p * 5 + p / 7) % 4, (p * 13 + 3) & 16'hFFFF);
        run(64, 5, "R3/R7 full table", 0);

        finish_run();
    end
endmodule